// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Engine

This block moves incoming stream packets into memory by walking a linked chain of descriptors. A short side stream first supplies a five-word application header. The engine then takes a data packet and spreads it over as many descriptor buffers as the packet needs. After each buffer is filled, the engine writes a status word back into that descriptor. The status word carries start-of-frame, end-of-frame and completion flags and the number of words received. The descriptor that takes the final word also receives the stored header words.

The engine works on one descriptor at a time through a simple request/acknowledge memory master. A register block outside this design gives it the current descriptor pointer, the tail pointer and a run enable. The engine reports idle once it has finished the tail descriptor. It reports halted when it fetches a descriptor that is already marked complete. Data back-pressure follows run, idle and halted, so a packet that reaches the tail in its middle is held until software extends the chain. Lengths and counts are in 32-bit words.

Top module: `sg_rx_engine`

## Requirements
- R1: The control stream commits a header only when its packet (ended by `ctl_last_i`) has exactly five words. Any other length raises `ctl_err_o` for one cycle, on the cycle after the last word, and leaves the stored header unchanged. The stored header stays in effect for later packets.
- R2: A descriptor receives min(its length field, words of the packet still to come). Word i of that share is written to buffer address + i. The length field is bits 22:0 of the control word.
- R3: If a fetched status word has bit 31 set, the engine sets `halted_o`, writes nothing and keeps `rx_tready_o` low. Loading a new current pointer clears `halted_o`.
- R4: The status of the first descriptor of a packet has bit 27 set. Later descriptors of the same packet have bit 27 clear.
- R5: The descriptor that takes the last word gets status bit 26 set and the five stored header words at word offsets 4 to 8. `pkt_done_o` pulses for one cycle, in the cycle after that status write completes.
- R6: Each filled descriptor gets a status word at offset 3 with bit 31 set and bits 22:0 holding the words received. The engine then continues at the next pointer. The descriptor layout in word offsets is: 0 next pointer, 1 buffer address, 2 control, 3 status, 4 to 8 header.
- R7: Finishing the tail descriptor sets `idle_o`. A tail-pointer write clears it. If a tail write lands in the same cycle as the tail descriptor finishes, the write wins and the engine continues.
- R8: `rx_tready_o` is high only while `run_i` is set and the engine is neither idle nor halted. If idle is reached mid-packet, the rest of the packet waits, unaccepted, until the next tail write.
- R9: After reset, `idle_o` and `halted_o` are set, `rx_tready_o` is low and no memory request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Channel run enable |
| cur_load_i | input | 1 | Load the current descriptor pointer |
| cur_ptr_i | input | AW | Current descriptor pointer value |
| tail_wr_i | input | 1 | Tail pointer write strobe |
| tail_ptr_i | input | AW | Tail descriptor pointer value |
| ctl_valid_i | input | 1 | Header stream word valid |
| ctl_data_i | input | 32 | Header stream word |
| ctl_last_i | input | 1 | Last word of the header packet |
| ctl_err_o | output | 1 | Header length error pulse |
| rx_tvalid_i | input | 1 | Data stream valid |
| rx_tdata_i | input | 32 | Data stream word |
| rx_tlast_i | input | 1 | Last word of the data packet |
| rx_tready_o | output | 1 | Data stream ready |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Memory read data |
| idle_o | output | 1 | Tail descriptor finished |
| halted_o | output | 1 | Stopped on an already-complete descriptor |
| pkt_done_o | output | 1 | Packet completion pulse |

## Verification
The most delicate case is a tail-pointer write that arrives in the same cycle as the engine finishes the status write of the current tail descriptor. In that cycle the idle flag is asked to set and to clear at once. The bench watches the memory port for the tail descriptor's status write. It raises the tail strobe, with a pointer to a pre-completed descriptor, in exactly the acknowledge cycle. The expected result is that idle stays clear and the engine goes on to fetch that descriptor and halt. Had the write been lost, idle would be set and halted would stay clear, and both observations are checked.

// File: rtl/sg_rx_pkg.sv
package sg_rx_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned OFS_STAT      = 3;
  localparam int unsigned OFS_APP       = 4;
  localparam int unsigned STAT_DONE_BIT = 31;
  localparam int unsigned STAT_SOF_BIT  = 27;
  localparam int unsigned STAT_EOF_BIT  = 26;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_FETCH,
    ST_DATA,
    ST_WDATA,
    ST_APP,
    ST_STAT
  } rx_state_e;
endpackage

// File: rtl/sg_rx_app_store.sv
module sg_rx_app_store #(
  parameter int unsigned APP_WORDS = 5,
  localparam int unsigned CW = $clog2(APP_WORDS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ctl_valid_i,
  input  logic [31:0]              ctl_data_i,
  input  logic                     ctl_last_i,
  output logic [APP_WORDS*32-1:0]  app_o,
  output logic                     err_o
);
  logic [CW-1:0] cnt_q;
  logic [31:0]   stage_q [APP_WORDS];
  logic [31:0]   app_q   [APP_WORDS];
  logic          err_q;
  logic          full_len;

  // current beat is the final word of a correctly sized header
  assign full_len = (cnt_q == CW'(APP_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < int'(APP_WORDS); i++) begin
        stage_q[i] <= '0;
        app_q[i]   <= '0;
      end
    end else begin
      err_q <= 1'b0;
      if (ctl_valid_i) begin
        if (ctl_last_i) begin
          cnt_q <= '0;
          err_q <= !full_len;
          if (full_len) begin
            for (int i = 0; i < int'(APP_WORDS); i++)
              app_q[i] <= (i == int'(APP_WORDS) - 1) ? ctl_data_i : stage_q[i];
          end
        end else if (cnt_q < CW'(APP_WORDS)) begin
          stage_q[cnt_q] <= ctl_data_i;
          cnt_q          <= cnt_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < int'(APP_WORDS); g++) begin : g_pack
    assign app_o[g*32 +: 32] = app_q[g];
  end

  assign err_o = err_q;

  AST_ERR_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(ctl_valid_i && ctl_last_i)) else $error("err without last"); // R1
endmodule

// File: rtl/sg_rx_chain.sv
module sg_rx_chain #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cur_load_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic          tail_wr_i,
  input  logic [AW-1:0] tail_ptr_i,
  input  logic          advance_i,
  input  logic          eof_i,
  input  logic [AW-1:0] next_ptr_i,
  input  logic          halt_set_i,
  output logic [AW-1:0] cur_o,
  output logic          idle_o,
  output logic          halted_o,
  output logic          sof_pend_o,
  output logic          pkt_done_o
);
  logic [AW-1:0] cur_q, tail_q;
  logic          idle_q, halted_q, sof_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      tail_q   <= '0;
      idle_q   <= 1'b1;
      halted_q <= 1'b1;
      sof_q    <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= advance_i && eof_i;
      if (cur_load_i) begin
        cur_q    <= cur_ptr_i;
        halted_q <= 1'b0;
        sof_q    <= 1'b1;
      end else begin
        if (advance_i) begin
          cur_q <= next_ptr_i;
          sof_q <= eof_i;
        end
        if (halt_set_i) halted_q <= 1'b1;
      end
      if (tail_wr_i) tail_q <= tail_ptr_i;
      // a fresh tail write outranks reaching the old tail
      if (tail_wr_i)                          idle_q <= 1'b0;
      else if (advance_i && cur_q == tail_q)  idle_q <= 1'b1;
    end
  end

  assign cur_o      = cur_q;
  assign idle_o     = idle_q;
  assign halted_o   = halted_q;
  assign sof_pend_o = sof_q;
  assign pkt_done_o = done_q;

  AST_TAIL_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_wr_i |=> !idle_o) else $error("tail write left idle set"); // R7
endmodule

// File: rtl/sg_rx_engine.sv
module sg_rx_engine
  import sg_rx_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned LEN_W     = 23,
  parameter int unsigned APP_WORDS = 5,
  localparam int unsigned APP_IW   = $clog2(APP_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cur_load_i,
  input  logic [AW-1:0]     cur_ptr_i,
  input  logic              tail_wr_i,
  input  logic [AW-1:0]     tail_ptr_i,
  input  logic              ctl_valid_i,
  input  logic [WORD_W-1:0] ctl_data_i,
  input  logic              ctl_last_i,
  output logic              ctl_err_o,
  input  logic              rx_tvalid_i,
  input  logic [WORD_W-1:0] rx_tdata_i,
  input  logic              rx_tlast_i,
  output logic              rx_tready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              idle_o,
  output logic              halted_o,
  output logic              pkt_done_o
);
  rx_state_e             state_q;
  logic [1:0]            fetch_idx_q;
  logic [AW-1:0]         nxt_q, buf_q, cur;
  logic [LEN_W-1:0]      len_q, cnt_q;
  logic [WORD_W-1:0]     beat_q, status_w;
  logic                  eof_q, sof_pend, go, advance, halt_set, beat_take;
  logic [APP_IW-1:0]     app_idx_q;
  logic [APP_WORDS*32-1:0] app_flat;

  sg_rx_app_store #(.APP_WORDS(APP_WORDS)) u_app (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_valid_i (ctl_valid_i),
    .ctl_data_i  (ctl_data_i),
    .ctl_last_i  (ctl_last_i),
    .app_o       (app_flat),
    .err_o       (ctl_err_o)
  );

  sg_rx_chain #(.AW(AW)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_load_i (cur_load_i),
    .cur_ptr_i  (cur_ptr_i),
    .tail_wr_i  (tail_wr_i),
    .tail_ptr_i (tail_ptr_i),
    .advance_i  (advance),
    .eof_i      (eof_q),
    .next_ptr_i (nxt_q),
    .halt_set_i (halt_set),
    .cur_o      (cur),
    .idle_o     (idle_o),
    .halted_o   (halted_o),
    .sof_pend_o (sof_pend),
    .pkt_done_o (pkt_done_o)
  );

  assign go          = run_i && !idle_o && !halted_o;
  assign rx_tready_o = (state_q == ST_DATA) && run_i && (cnt_q != len_q);
  assign beat_take   = rx_tready_o && rx_tvalid_i;
  assign advance     = (state_q == ST_STAT) && mem_ack_i;
  assign halt_set    = (state_q == ST_FETCH) && mem_ack_i && (fetch_idx_q == 2'd3)
                       && mem_rdata_i[STAT_DONE_BIT];

  always_comb begin
    status_w                = '0;
    status_w[LEN_W-1:0]     = cnt_q;
    status_w[STAT_DONE_BIT] = 1'b1;
    status_w[STAT_SOF_BIT]  = sof_pend;
    status_w[STAT_EOF_BIT]  = eof_q;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b1;
    mem_addr_o  = cur;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b0;
        mem_addr_o = cur + AW'(fetch_idx_q);
      end
      ST_WDATA: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = buf_q + AW'(cnt_q);
        mem_wdata_o = beat_q;
      end
      ST_APP: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = cur + AW'(OFS_APP) + AW'(app_idx_q);
        mem_wdata_o = app_flat[32*int'(app_idx_q) +: 32];
      end
      ST_STAT: begin
        mem_req_o   = 1'b1;
        mem_addr_o  = cur + AW'(OFS_STAT);
        mem_wdata_o = status_w;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_WAIT;
      fetch_idx_q <= '0;
      nxt_q       <= '0;
      buf_q       <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      beat_q      <= '0;
      eof_q       <= 1'b0;
      app_idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT: if (go) begin
          state_q     <= ST_FETCH;
          fetch_idx_q <= '0;
        end
        ST_FETCH: if (mem_ack_i) begin
          fetch_idx_q <= fetch_idx_q + 1'b1;
          unique case (fetch_idx_q)
            2'd0: nxt_q <= mem_rdata_i[AW-1:0];
            2'd1: buf_q <= mem_rdata_i[AW-1:0];
            2'd2: len_q <= mem_rdata_i[LEN_W-1:0];
            default: begin
              cnt_q   <= '0;
              eof_q   <= 1'b0;
              state_q <= mem_rdata_i[STAT_DONE_BIT] ? ST_WAIT : ST_DATA;
            end
          endcase
        end
        ST_DATA: begin
          if (cnt_q == len_q) begin
            state_q <= ST_STAT;
          end else if (beat_take) begin
            beat_q  <= rx_tdata_i;
            eof_q   <= rx_tlast_i;
            state_q <= ST_WDATA;
          end
        end
        ST_WDATA: if (mem_ack_i) begin
          cnt_q     <= cnt_q + 1'b1;
          app_idx_q <= '0;
          state_q   <= eof_q ? ST_APP : ST_DATA;
        end
        ST_APP: if (mem_ack_i) begin
          if (app_idx_q == APP_IW'(APP_WORDS - 1)) state_q <= ST_STAT;
          else app_idx_q <= app_idx_q + 1'b1;
        end
        ST_STAT: if (mem_ack_i) state_q <= ST_WAIT;
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{mem_rdata_i[WORD_W-1:LEN_W]};

  AST_TREADY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tready_o |-> (!idle_o && !halted_o)) else $error("ready while stopped"); // R8
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o) else $error("memory access while halted"); // R3
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA) |-> (cnt_q < len_q)) else $error("buffer overrun"); // R2
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)))
    else $error("request dropped"); // R6
  AST_DONE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i
                         && mem_wdata_o[STAT_EOF_BIT] && mem_wdata_o[STAT_DONE_BIT]))
    else $error("done without end status"); // R5
endmodule

// File: tb/sg_rx_engine_tb_top.sv
`timescale 1ns/1ps
module sg_rx_engine_tb_top;
  typedef struct { logic [15:0] a; logic [31:0] d; string tag; } wr_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, cur_load = 1'b0, tail_wr = 1'b0;
  logic [15:0] cur_ptr = '0, tail_ptr = '0;
  logic ctl_valid = 1'b0, ctl_last = 1'b0, ctl_err;
  logic [31:0] ctl_data = '0;
  logic rx_tvalid = 1'b0, rx_tlast = 1'b0, rx_tready;
  logic [31:0] rx_tdata = '0;
  logic mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic idle, halted, pkt_done;
  logic [31:0] mem [0:255];
  int n_chk = 0, n_bad = 0;
  wr_t exp_q[$];
  int done_due = 0;

  always #2.5 clk = ~clk;

  sg_rx_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .cur_load_i(cur_load), .cur_ptr_i(cur_ptr), .tail_wr_i(tail_wr), .tail_ptr_i(tail_ptr),
    .ctl_valid_i(ctl_valid), .ctl_data_i(ctl_data), .ctl_last_i(ctl_last), .ctl_err_o(ctl_err),
    .rx_tvalid_i(rx_tvalid), .rx_tdata_i(rx_tdata), .rx_tlast_i(rx_tlast), .rx_tready_o(rx_tready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .idle_o(idle), .halted_o(halted), .pkt_done_o(pkt_done)
  );

  function automatic logic [31:0] dlen(int k);
    case (k)
      1: return 32'd3;  2: return 32'd4;  3: return 32'd4;
      4: return 32'd2;  5: return 32'd2;  6: return 32'd1;
      default: return 32'd2;
    endcase
  endfunction

  // memory: descriptor k at 0x10*k, buffer at 0x80+8k, chain is linear, 7th is pre-completed
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      for (int k = 1; k < 8; k++) begin
        mem[16*k]     <= 32'(16*(k+1));
        mem[16*k + 1] <= 32'(128 + 8*k);
        mem[16*k + 2] <= dlen(k);
        mem[16*k + 3] <= (k == 7) ? 32'h8000_0000 : 32'h0;
      end
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_we && mem_ack) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end
  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_w(input logic [15:0] a, input logic [31:0] d, input string tag);
    wr_t w;
    w.a = a; w.d = d; w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic exp_app(input logic [15:0] desc, input logic [31:0] base);
    for (int i = 0; i < 5; i++) exp_w(desc + 16'(4 + i), base + 32'(i), "R5 header word");
  endtask

  // monitor: compares every completed write against the scoreboard
  always @(negedge clk) begin
    if (done_due != 0) begin
      check(pkt_done == (done_due == 2), "R5 pkt_done", 32'(pkt_done), 32'(done_due == 2));
      done_due = 0;
    end
    if (rst_n && mem_req && mem_we && mem_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R6 unexpected write", {mem_addr, 16'h0}, 32'h0);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        check(mem_addr == w.a, {w.tag, " addr"}, 32'(mem_addr), 32'(w.a));
        check(mem_wdata == w.d, {w.tag, " data"}, mem_wdata, w.d);
        if (w.a[3:0] == 4'h3) done_due = w.d[26] ? 2 : 1;
      end
    end
  end

  task automatic strobe_tail(input logic [15:0] p);
    @(negedge clk); tail_wr = 1'b1; tail_ptr = p;
    @(negedge clk); tail_wr = 1'b0;
  endtask

  task automatic send_hdr(input logic [31:0] base, input int n, input bit exp_err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ctl_valid = 1'b1; ctl_data = base + 32'(i); ctl_last = (i == n - 1);
    end
    @(negedge clk);
    ctl_valid = 1'b0; ctl_last = 1'b0;
    check(ctl_err == exp_err, "R1 header length flag", 32'(ctl_err), 32'(exp_err));
  endtask

  task automatic send_pkt(input logic [31:0] base, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      bit hs;
      rx_tvalid = 1'b1; rx_tdata = base + 32'(i); rx_tlast = (i == n - 1);
      forever begin
        hs = rx_tready;
        @(negedge clk);
        if (hs) break;
      end
    end
    rx_tvalid = 1'b0; rx_tlast = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(idle == 1'b1, "R9 idle after reset", 32'(idle), 32'd1);
    check(halted == 1'b1, "R9 halted after reset", 32'(halted), 32'd1);
    check(rx_tready == 1'b0, "R9 ready after reset", 32'(rx_tready), 32'd0);
    check(mem_req == 1'b0, "R9 no request after reset", 32'(mem_req), 32'd0);

    send_hdr(32'hA000_0000, 5, 1'b0);
    run = 1'b1;
    @(negedge clk); cur_load = 1'b1; cur_ptr = 16'h10;
    @(negedge clk); cur_load = 1'b0;
    check(halted == 1'b0, "R3 pointer load clears halt", 32'(halted), 32'd0);
    strobe_tail(16'h30);

    // packet of 5 across D1 (len 3) and D2 (len 4, gets 2): R2 R4 R5 R6
    exp_w(16'h88, 32'h100, "R2 data"); exp_w(16'h89, 32'h101, "R2 data");
    exp_w(16'h8A, 32'h102, "R2 data"); exp_w(16'h13, 32'h8800_0003, "R4 first status");
    exp_w(16'h90, 32'h103, "R2 data"); exp_w(16'h91, 32'h104, "R2 data");
    exp_app(16'h20, 32'hA000_0000);
    exp_w(16'h23, 32'h8400_0002, "R2/R6 last status no sof");
    send_pkt(32'h100, 5);
    drain();

    send_hdr(32'hC000_0000, 3, 1'b1);

    // single-descriptor packet into D3, the tail: R1 old header kept, R7 idle
    exp_w(16'h98, 32'h200, "R2 data"); exp_w(16'h99, 32'h201, "R2 data");
    exp_app(16'h30, 32'hA000_0000);
    exp_w(16'h33, 32'h8C00_0002, "R4/R5 sof+eof status");
    send_pkt(32'h200, 2);
    drain();
    check(idle == 1'b1, "R7 idle at tail", 32'(idle), 32'd1);
    check(rx_tready == 1'b0, "R8 ready low when idle", 32'(rx_tready), 32'd0);

    // new header, then a packet that runs into the tail mid-way: R8
    send_hdr(32'hB000_0000, 5, 1'b0);
    strobe_tail(16'h40);
    exp_w(16'hA0, 32'h300, "R2 data"); exp_w(16'hA1, 32'h301, "R2 data");
    exp_w(16'h43, 32'h8800_0002, "R6 status mid-packet");
    fork
      send_pkt(32'h300, 3);
      begin
        bit seen_ready;
        drain();
        seen_ready = 1'b0;
        for (int i = 0; i < 20; i++) begin
          @(negedge clk);
          if (rx_tready || mem_req) seen_ready = 1'b1;
        end
        check(!seen_ready, "R8 remainder held while idle", 32'(seen_ready), 32'd0);
        check(idle == 1'b1, "R7 idle mid-packet", 32'(idle), 32'd1);
        exp_w(16'hA8, 32'h302, "R2 data");
        exp_app(16'h50, 32'hB000_0000);
        exp_w(16'h53, 32'h8400_0001, "R5 end status no sof");
        strobe_tail(16'h50);
      end
    join
    drain();

    // tail write coinciding with the tail's status write: R7, then halt on D7: R3
    exp_w(16'hB0, 32'h400, "R2 data");
    exp_app(16'h60, 32'hB000_0000);
    exp_w(16'h63, 32'h8C00_0001, "R6 single-word status");
    strobe_tail(16'h60);
    fork
      send_pkt(32'h400, 1);
      begin
        do @(negedge clk); while (!(mem_req && mem_we && mem_ack && mem_addr == 16'h63));
        tail_wr = 1'b1; tail_ptr = 16'h70;
        @(negedge clk); tail_wr = 1'b0;
      end
    join
    drain();
    repeat (20) @(negedge clk);
    check(idle == 1'b0, "R7 same-cycle tail write wins", 32'(idle), 32'd0);
    check(halted == 1'b1, "R3 halted on completed descriptor", 32'(halted), 32'd1);
    check(rx_tready == 1'b0, "R3 ready low when halted", 32'(rx_tready), 32'd0);
    check(mem[8'h73] == 32'h8000_0000, "R3 completed descriptor untouched", mem[8'h73], 32'h8000_0000);
    @(negedge clk); cur_load = 1'b1; cur_ptr = 16'h70;
    @(negedge clk); cur_load = 1'b0;
    check(halted == 1'b0, "R3 halt cleared by pointer load", 32'(halted), 32'd0);
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R3 halts again on same descriptor", 32'(halted), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule